// File: doc/BRIEF.md
# Staggered Per-Bank Refresh Scheduler

This block plans per-bank refresh for a single rank of `NUM_BANKS` banks. Every bank keeps its own refresh deadline, and the deadlines are staggered by one clock from bank to bank so that no two banks need the command bus in the same cycle. A fixed lead time before each deadline, the bank's trigger fires. If the bank has an open row, the block first requests a precharge of that bank and then a per-bank refresh. If the bank is closed, it requests the refresh straight away. Requests leave on one valid/ready port, which carries the command kind and the bank index.

The block also serves the command scheduler as a guard. The scheduler presents the kind of command it intends (activate, read or write), the target bank and the earliest cycle it could issue. The guard replies whether that command would run into the bank's coming refresh. If it would, the guard returns the first cycle after that refresh completes. All times are absolute cycle counts from a free-running counter, which the block exports.

Top module: `perbank_refresh_sched`

## Requirements
- R1: After reset, the refresh deadline of bank b is `T_REFI_PB - (NUM_BANKS-1) + b` cycles.
- R2: The trigger of each bank lies `max(NUM_BANKS, T_RP)` cycles before its deadline. A bank's request first becomes visible in the cycle in which `now_cycle` equals the trigger plus one.
- R3: When the refresh request of a bank is accepted, that bank's trigger and deadline both move `T_REFI_PB` cycles later. The other banks are not affected.
- R4: When several banks are waiting, the request offered is the one whose trigger is earliest.
- R5: For an activate (`guard_cmd` = 0), the command is blocked when `guard_earliest + T_RAS` is at or after the bank's trigger and `guard_earliest` is before deadline + `T_RFC_PB`. When blocked, `guard_start` is deadline + `T_RFC_PB`. Otherwise `guard_start` equals `guard_earliest`.
- R6: A read (`guard_cmd` = 1) follows the R5 rule with `T_RTP` as the margin.
- R7: A write (`guard_cmd` = 2) follows the R5 rule with `T_WL + T_CCD + T_WR` as the margin.
- R8: `req_cmd` is 0 for precharge and 1 for refresh. A bank whose `bank_open` bit is 1 at its trigger cycle requests a precharge, then a refresh once the precharge is accepted. A bank whose bit is 0 requests only the refresh.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_bank` and `req_cmd` hold their values.
- R10: During reset `now_cycle` is 0 and no request is offered. After reset, `now_cycle` advances by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_open | input | NUM_BANKS | One bit per bank, set while the bank has a row open |
| req_valid | output | 1 | A refresh-related request is offered |
| req_ready | input | 1 | The request is accepted in this cycle |
| req_cmd | output | 1 | 0 = precharge the bank, 1 = refresh the bank |
| req_bank | output | BANK_W | Bank that the request targets |
| guard_cmd | input | 2 | Intended command: 0 activate, 1 read, 2 write |
| guard_bank | input | BANK_W | Bank of the intended command |
| guard_earliest | input | TIME_W | Earliest cycle at which the intended command could issue |
| guard_blocked | output | 1 | The intended command would collide with the bank's refresh |
| guard_start | output | TIME_W | Cycle at which the intended command may issue |
| now_cycle | output | TIME_W | Free-running cycle count since reset |

## Verification
The assertions assume four things about the environment:
- `now_cycle` never wraps within a run.
- `guard_cmd` holds only the codes 0 to 2.
- `guard_earliest` lies no more than a refresh interval ahead of the present cycle.
- `req_ready` may drop at any time.

The stimulus keeps to these limits. It runs a few thousand cycles on a 32-bit counter, draws the guard kind from the three legal codes, and draws the earliest cycle within one interval of the present. It holds ready low through the whole first round, so that every bank is waiting at once. After that it toggles ready and the open-row bits at random, so that both the precharge path and the direct refresh path come up for every bank.

// File: rtl/prb_pkg.sv
package prb_pkg;

    typedef enum logic [1:0] {
        BST_IDLE    = 2'd0,
        BST_PRE_REQ = 2'd1,
        BST_REF_REQ = 2'd2
    } bank_state_e;

    typedef enum logic {
        RCMD_PRE  = 1'b0,
        RCMD_REFB = 1'b1
    } req_cmd_e;

    typedef enum logic [1:0] {
        GCMD_ACT = 2'd0,
        GCMD_RD  = 2'd1,
        GCMD_WR  = 2'd2
    } guard_cmd_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prb_bank_timer.sv
module prb_bank_timer
    import prb_pkg::*;
#(
    parameter int TIME_W   = 32,
    parameter int INIT_DL  = 481,
    parameter int LEAD     = 10,
    parameter int INTERVAL = 488
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now,
    input  logic              row_open,
    input  logic              grant,
    output logic              pending,
    output req_cmd_e          cmd,
    output logic [TIME_W-1:0] trig_time,
    output logic [TIME_W-1:0] deadline
);

    localparam logic [TIME_W-1:0] STEP = TIME_W'(INTERVAL);

    bank_state_e       state_q;
    logic [TIME_W-1:0] trig_q;
    logic [TIME_W-1:0] dl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BST_IDLE;
            dl_q    <= TIME_W'(INIT_DL);
            trig_q  <= TIME_W'(INIT_DL - LEAD);
        end else begin
            case (state_q)
                BST_IDLE: begin
                    if (now == trig_q)
                        state_q <= row_open ? BST_PRE_REQ : BST_REF_REQ;
                end
                BST_PRE_REQ: begin
                    if (grant)
                        state_q <= BST_REF_REQ;
                end
                BST_REF_REQ: begin
                    if (grant) begin
                        state_q <= BST_IDLE;
                        trig_q  <= trig_q + STEP;
                        dl_q    <= dl_q + STEP;
                    end
                end
                default: state_q <= BST_IDLE;
            endcase
        end
    end

    assign pending   = (state_q != BST_IDLE);
    assign cmd       = (state_q == BST_PRE_REQ) ? RCMD_PRE : RCMD_REFB;
    assign trig_time = trig_q;
    assign deadline  = dl_q;

    // R2: a bank only waits once its trigger cycle has passed
    a_r2_wait_after_trigger: assert property (@(posedge clk) disable iff (rst)
        (state_q != BST_IDLE) |-> (now > trig_q));

    // R3: an accepted refresh moves both times one interval on
    a_r3_next_interval: assert property (@(posedge clk) disable iff (rst)
        (state_q == BST_REF_REQ && grant) |=>
            (trig_q == $past(trig_q) + STEP) && (dl_q == $past(dl_q) + STEP));

endmodule

// File: rtl/prb_req_arb.sv
module prb_req_arb
    import prb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int TIME_W    = 32,
    parameter int BANK_W    = 3
) (
    input  logic [NUM_BANKS-1:0] pending,
    input  req_cmd_e             cmd_in   [NUM_BANKS],
    input  logic [TIME_W-1:0]    trig_in  [NUM_BANKS],
    output logic                 any_valid,
    output logic [BANK_W-1:0]    sel_bank,
    output req_cmd_e             sel_cmd
);

    logic [TIME_W-1:0] best_time;

    always_comb begin
        any_valid = 1'b0;
        sel_bank  = '0;
        sel_cmd   = RCMD_PRE;
        best_time = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (pending[i] && (!any_valid || trig_in[i] < best_time)) begin
                any_valid = 1'b1;
                sel_bank  = BANK_W'(i);
                sel_cmd   = cmd_in[i];
                best_time = trig_in[i];
            end
        end
    end

endmodule

// File: rtl/prb_refresh_guard.sv
module prb_refresh_guard
    import prb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int TIME_W    = 32,
    parameter int BANK_W    = 3,
    parameter int T_RAS     = 34,
    parameter int T_RTP     = 8,
    parameter int T_WL      = 8,
    parameter int T_CCD     = 8,
    parameter int T_WR      = 18,
    parameter int T_RFC_PB  = 90
) (
    input  logic [1:0]        cmd_code,
    input  logic [BANK_W-1:0] bank,
    input  logic [TIME_W-1:0] earliest,
    input  logic [TIME_W-1:0] trig_in [NUM_BANKS],
    input  logic [TIME_W-1:0] dl_in   [NUM_BANKS],
    output logic              blocked,
    output logic [TIME_W-1:0] start
);

    localparam logic [TIME_W-1:0] M_ACT = TIME_W'(T_RAS);
    localparam logic [TIME_W-1:0] M_RD  = TIME_W'(T_RTP);
    localparam logic [TIME_W-1:0] M_WR  = TIME_W'(T_WL + T_CCD + T_WR);
    localparam logic [TIME_W-1:0] M_RFC = TIME_W'(T_RFC_PB);

    logic [TIME_W-1:0] trig_sel;
    logic [TIME_W-1:0] dl_sel;
    logic [TIME_W-1:0] margin;
    logic [TIME_W-1:0] free_at;

    always_comb begin
        trig_sel = trig_in[0];
        dl_sel   = dl_in[0];
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank == BANK_W'(i)) begin
                trig_sel = trig_in[i];
                dl_sel   = dl_in[i];
            end
        end
    end

    always_comb begin
        case (guard_cmd_e'(cmd_code))
            GCMD_RD: margin = M_RD;
            GCMD_WR: margin = M_WR;
            default: margin = M_ACT;
        endcase
    end

    assign free_at = dl_sel + M_RFC;
    assign blocked = (earliest + margin >= trig_sel) && (earliest < free_at);
    assign start   = blocked ? free_at : earliest;

endmodule

// File: rtl/perbank_refresh_sched.sv
module perbank_refresh_sched
    import prb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int TIME_W    = 32,
    parameter int T_REFI_PB = 488,
    parameter int T_RP      = 10,
    parameter int T_RAS     = 34,
    parameter int T_RTP     = 8,
    parameter int T_WL      = 8,
    parameter int T_CCD     = 8,
    parameter int T_WR      = 18,
    parameter int T_RFC_PB  = 90,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic                 req_cmd,
    output logic [BANK_W-1:0]    req_bank,
    input  logic [1:0]           guard_cmd,
    input  logic [BANK_W-1:0]    guard_bank,
    input  logic [TIME_W-1:0]    guard_earliest,
    output logic                 guard_blocked,
    output logic [TIME_W-1:0]    guard_start,
    output logic [TIME_W-1:0]    now_cycle
);

    localparam int LEAD     = max_of(NUM_BANKS, T_RP);
    localparam int FIRST_DL = T_REFI_PB - (NUM_BANKS - 1);

    logic [TIME_W-1:0]    now_q;
    logic [NUM_BANKS-1:0] pend;
    logic [NUM_BANKS-1:0] grant;
    req_cmd_e             bank_cmd  [NUM_BANKS];
    logic [TIME_W-1:0]    bank_trig [NUM_BANKS];
    logic [TIME_W-1:0]    bank_dl   [NUM_BANKS];
    req_cmd_e             arb_cmd;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end
    assign now_cycle = now_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign grant[b] = req_valid && req_ready && (req_bank == BANK_W'(b));

        prb_bank_timer #(
            .TIME_W   (TIME_W),
            .INIT_DL  (FIRST_DL + b),
            .LEAD     (LEAD),
            .INTERVAL (T_REFI_PB)
        ) timer_i (
            .clk       (clk),
            .rst       (rst),
            .now       (now_q),
            .row_open  (bank_open[b]),
            .grant     (grant[b]),
            .pending   (pend[b]),
            .cmd       (bank_cmd[b]),
            .trig_time (bank_trig[b]),
            .deadline  (bank_dl[b])
        );
    end

    prb_req_arb #(
        .NUM_BANKS (NUM_BANKS),
        .TIME_W    (TIME_W),
        .BANK_W    (BANK_W)
    ) arb_i (
        .pending   (pend),
        .cmd_in    (bank_cmd),
        .trig_in   (bank_trig),
        .any_valid (req_valid),
        .sel_bank  (req_bank),
        .sel_cmd   (arb_cmd)
    );
    assign req_cmd = arb_cmd;

    prb_refresh_guard #(
        .NUM_BANKS (NUM_BANKS),
        .TIME_W    (TIME_W),
        .BANK_W    (BANK_W),
        .T_RAS     (T_RAS),
        .T_RTP     (T_RTP),
        .T_WL      (T_WL),
        .T_CCD     (T_CCD),
        .T_WR      (T_WR),
        .T_RFC_PB  (T_RFC_PB)
    ) guard_i (
        .cmd_code (guard_cmd),
        .bank     (guard_bank),
        .earliest (guard_earliest),
        .trig_in  (bank_trig),
        .dl_in    (bank_dl),
        .blocked  (guard_blocked),
        .start    (guard_start)
    );

    // R9: an offered request stays put until it is taken
    a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_bank) && $stable(req_cmd)));

    // R8: an accepted precharge is followed by the same bank's refresh
    a_r8_pre_then_refresh: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_cmd == RCMD_PRE) |=>
            (req_valid && req_bank == $past(req_bank) && req_cmd == RCMD_REFB));

    // R5: a pushed command always lands later than asked
    a_r5_push_is_later: assert property (@(posedge clk) disable iff (rst)
        guard_blocked |-> (guard_start > guard_earliest));

    // R5: an unblocked command keeps its own cycle
    a_r5_free_keeps_time: assert property (@(posedge clk) disable iff (rst)
        !guard_blocked |-> (guard_start == guard_earliest));

    // R10: the cycle counter moves by one every cycle
    a_r10_time_steps: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (now_q == $past(now_q) + 1'b1));

endmodule

// File: tb/perbank_refresh_sched_tb_top.sv
module perbank_refresh_sched_tb_top;

    localparam int N      = 8;
    localparam int TW     = 32;
    localparam int BW     = 3;
    localparam int INTV   = 488;
    localparam int TRP    = 10;
    localparam int TRAS   = 34;
    localparam int TRTP   = 8;
    localparam int TWL    = 8;
    localparam int TCCD   = 8;
    localparam int TWR    = 18;
    localparam int TRFC   = 90;
    localparam int LEADC  = (N > TRP) ? N : TRP;
    localparam int STEPS  = 3200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  bank_open = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic          req_cmd;
    logic [BW-1:0] req_bank;
    logic [1:0]    guard_cmd = 2'd0;
    logic [BW-1:0] guard_bank = '0;
    logic [TW-1:0] guard_earliest = '0;
    logic          guard_blocked;
    logic [TW-1:0] guard_start;
    logic [TW-1:0] now_cycle;

    always #5 clk = ~clk;

    perbank_refresh_sched dut_i (
        .clk            (clk),
        .rst            (rst),
        .bank_open      (bank_open),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_cmd        (req_cmd),
        .req_bank       (req_bank),
        .guard_cmd      (guard_cmd),
        .guard_bank     (guard_bank),
        .guard_earliest (guard_earliest),
        .guard_blocked  (guard_blocked),
        .guard_start    (guard_start),
        .now_cycle      (now_cycle)
    );

    int    n_checks = 0;
    int    n_bad    = 0;
    bit    finished = 0;
    longint m_trig [N];
    longint m_dl   [N];
    int     m_phase[N];   // 0 waiting for trigger, 1 precharge wanted, 2 refresh wanted
    int     m_refs [N];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint margin_of(input int c);
        if (c == 1) return longint'(TRTP);
        if (c == 2) return longint'(TWL + TCCD + TWR);
        return longint'(TRAS);
    endfunction

    function automatic string tag_of(input int c);
        if (c == 1) return "R6";
        if (c == 2) return "R7";
        return "R5";
    endfunction

    task automatic guard_probe(input int c, input int b, input longint e, input string req);
        longint exp_start;
        bit     exp_blk;
        guard_cmd      = 2'(c);
        guard_bank     = BW'(b);
        guard_earliest = TW'(e);
        #1;
        exp_blk   = (e + margin_of(c) >= m_trig[b]) && (e < m_dl[b] + TRFC);
        exp_start = exp_blk ? (m_dl[b] + TRFC) : e;
        check(guard_blocked == exp_blk, req, $sformatf("blocked bank%0d e=%0d", b, e),
              longint'(guard_blocked), longint'(exp_blk));
        check(longint'(guard_start) == exp_start, req, $sformatf("start bank%0d", b),
              longint'(guard_start), exp_start);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin : main
        longint cyc;
        void'($urandom(32'h1F2E3D4C));
        for (int b = 0; b < N; b++) begin
            m_dl[b]    = longint'(INTV - (N - 1) + b);   // R1
            m_trig[b]  = m_dl[b] - LEADC;                // R2
            m_phase[b] = 0;
            m_refs[b]  = 0;
        end

        repeat (2) @(negedge clk);
        #1;
        check(now_cycle == '0, "R10", "now during reset", longint'(now_cycle), 0);
        check(req_valid == 1'b0, "R10", "valid during reset", longint'(req_valid), 0);

        // R1 / R2 boundaries, R5 R6 R7 rules at the first and last bank
        for (int k = 0; k < 2; k++) begin
            int b = (k == 0) ? 0 : N - 1;
            for (int c = 0; c < 3; c++) begin
                guard_probe(c, b, m_trig[b] - margin_of(c) - 1, "R1");
                guard_probe(c, b, m_trig[b] - margin_of(c), tag_of(c));
                guard_probe(c, b, m_dl[b] + TRFC - 1, "R2");
                guard_probe(c, b, m_dl[b] + TRFC, tag_of(c));
            end
        end

        @(negedge clk);
        rst = 1'b0;
        cyc = 0;

        for (int s = 0; s < STEPS; s++) begin
            bit     exp_v;
            int     exp_b;
            bit     will_take;
            // time base
            #1;
            check(longint'(now_cycle) == cyc, "R10", "now_cycle", longint'(now_cycle), cyc);
            // random guard probe against the model
            begin
                int c = int'($urandom % 3);
                int b = int'($urandom % N);
                guard_probe(c, b, cyc + longint'($urandom % INTV),
                            (m_refs[b] > 0) ? "R3" : tag_of(c));
            end
            // expected request
            exp_v = 0;
            exp_b = 0;
            for (int b = 0; b < N; b++) begin
                if (m_phase[b] != 0 && (!exp_v || m_trig[b] < m_trig[exp_b])) begin
                    exp_v = 1;
                    exp_b = b;
                end
            end
            check(req_valid == exp_v, "R2", "req_valid", longint'(req_valid), longint'(exp_v));
            if (exp_v) begin
                check(int'(req_bank) == exp_b, "R4", "req_bank", longint'(req_bank), longint'(exp_b));
                check(req_cmd == (m_phase[exp_b] == 2), "R8", "req_cmd",
                      longint'(req_cmd), longint'(m_phase[exp_b] == 2));
            end
            // drive next inputs: ready held low through the first round (R9, R4)
            bank_open = N'($urandom);
            if (cyc < m_trig[N-1] + 12 && m_refs[0] == 0) req_ready = 1'b0;
            else req_ready = ($urandom % 2) == 0;
            will_take = exp_v && req_ready;
            if (will_take) begin
                if (m_phase[exp_b] == 1) m_phase[exp_b] = 2;
                else begin
                    m_phase[exp_b] = 0;
                    m_trig[exp_b] += INTV;   // R3
                    m_dl[exp_b]   += INTV;
                    m_refs[exp_b]++;
                end
            end
            for (int b = 0; b < N; b++) begin
                if (m_phase[b] == 0 && cyc == m_trig[b])
                    m_phase[b] = bank_open[b] ? 1 : 2;   // R8
            end
            @(negedge clk);
            cyc++;
        end

        // R3: every bank has refreshed and its guard window moved on
        for (int b = 0; b < N; b++) begin
            check(m_refs[b] > 0, "R3", $sformatf("refreshes bank%0d", b), longint'(m_refs[b]), 1);
            guard_probe(0, b, m_trig[b] - TRAS, "R3");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule